// File: doc/BRIEF.md
# Two-Clock Request/Response Toggle Channel

This block links two pieces of logic that run on unrelated clocks. Each clock is treated as free-running, with no assumed ratio, multiple or phase between them. Side A hands over a request word through a valid/ready port. Side B receives the word as a one-cycle valid pulse in its own clock domain. Side B then answers through its own valid/ready port, and the answer arrives back at side A as a one-cycle valid pulse carrying the response word.

Only one signal crosses in each direction through a synchronizer: a toggle strobe. The sender inverts its strobe once per transfer. The receiver passes the strobe through a chain of D flip-flops and sees an event whenever the last two synchronized samples differ. The data word that goes with the strobe is held in a register on the sending side and is never synchronized bit by bit. The sender loads that register on the same edge that flips the strobe, and leaves it untouched until the next transfer. By the time the event emerges from the synchronizer the word has long settled, so the receiver captures it directly into its own clock domain.

Side A accepts one request at a time. It refuses new work until the response toggle for the current request has come back. This guarantees that neither held word changes while the other side may still be sampling it.

Top module: `xdom_req_resp`

## Requirements
- R1: While its reset is high, side A shows `a_req_ready`=1 and `a_rsp_valid`=0, and side B shows `b_req_valid`=0 and `b_rsp_ready`=0. Both toggle strobes and both synchronizer chains start at 0, so the first transfer after reset is a 0-to-1 change.
- R2: A request is accepted on a rising `clk_a` edge where `a_req_valid` and `a_req_ready` are both 1. In the next cycle `a_req_ready` is 0, and it stays 0 until the matching response is delivered.
- R3: Every accepted request produces exactly one `b_req_valid` pulse on side B, carrying the word that was accepted. Requests arrive in the order they were accepted, and no other pulses appear.
- R4: `b_req_valid` and `a_rsp_valid` are each high for exactly one cycle of their own clock per transfer.
- R5: `b_rsp_ready` is 1 from the cycle in which `b_req_valid` is high until a response is accepted, and 0 at all other times. A response offered while `b_rsp_ready` is 0 is ignored and never reaches side A.
- R6: A response accepted on side B (`b_rsp_valid` and `b_rsp_ready` both 1) produces exactly one `a_rsp_valid` pulse with that word on `a_rsp_data`. `a_req_ready` returns to 1 in that same cycle.
- R7: A request presented while `a_req_ready` is 0 is ignored: neither its data nor its valid reaches side B.
- R8: `b_req_data` and `a_rsp_data` keep their values in every cycle in which their valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a | input | 1 | Side A synchronous reset, active high |
| a_req_valid | input | 1 | Side A offers a request |
| a_req_ready | output | 1 | Side A can accept a request |
| a_req_data | input | REQ_W | Request word |
| a_rsp_valid | output | 1 | One-cycle response pulse on side A |
| a_rsp_data | output | RSP_W | Response word delivered to side A |
| clk_b | input | 1 | Side B clock |
| rst_b | input | 1 | Side B synchronous reset, active high |
| b_req_valid | output | 1 | One-cycle request pulse on side B |
| b_req_data | output | REQ_W | Request word delivered to side B |
| b_rsp_valid | input | 1 | Side B offers a response |
| b_rsp_ready | output | 1 | Side B is waiting for a response |
| b_rsp_data | input | RSP_W | Response word |

## Verification
A toggle or "seen" flop in the wrong state shows up at the ports as a lost or doubled valid pulse. A lost pulse leaves `a_req_ready` low forever, and the bench's wait for the response times out. A doubled pulse pops a scoreboard queue that is empty, within a few cycles of the receiving clock. If a held word is captured on the wrong cycle, the receiving side shows a data miscompare on the very pulse concerned. A busy or pending flag that is stuck shows up within one cycle, as a ready level that contradicts the handshake just completed.

// File: rtl/xdom_pkg.sv
package xdom_pkg;
  // default depth of every strobe synchronizer chain
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xdom_tgl_tx.sv
module xdom_tgl_tx #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         tgl,
  output logic [W-1:0] dhold
);
  // word and strobe move on the same edge; the receiver's synchronizer
  // delay gives the word its settling margin
  always_ff @(posedge clk) begin
    if (rst) begin
      tgl   <= 1'b0;
      dhold <= '0;
    end else if (load) begin
      tgl   <= ~tgl;
      dhold <= din;
    end
  end
endmodule

// File: rtl/xdom_tgl_rx.sv
module xdom_tgl_rx #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tgl_far,
  input  logic [W-1:0] din_far,
  output logic         hit,
  output logic         vld,
  output logic [W-1:0] dout
);
  logic tgl_s;
  logic seen_q;

  xdom_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (tgl_far),
    .q   (tgl_s)
  );

  assign hit = tgl_s ^ seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      vld    <= 1'b0;
      dout   <= '0;
    end else begin
      seen_q <= tgl_s;
      vld    <= hit;
      if (hit) dout <= din_far;
    end
  end
endmodule

// File: rtl/xdom_req_resp.sv
module xdom_req_resp
  import xdom_pkg::*;
#(
  parameter int unsigned REQ_W       = 16,
  parameter int unsigned RSP_W       = 12,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic             a_req_valid,
  output logic             a_req_ready,
  input  logic [REQ_W-1:0] a_req_data,
  output logic             a_rsp_valid,
  output logic [RSP_W-1:0] a_rsp_data,
  input  logic             clk_b,
  input  logic             rst_b,
  output logic             b_req_valid,
  output logic [REQ_W-1:0] b_req_data,
  input  logic             b_rsp_valid,
  output logic             b_rsp_ready,
  input  logic [RSP_W-1:0] b_rsp_data
);
  // ---------------- side A ----------------
  logic             busy_q;
  logic             take_a;
  logic             rsp_hit;
  logic             a2b_tgl;
  logic [REQ_W-1:0] a2b_word;

  assign a_req_ready = ~busy_q;
  assign take_a      = a_req_valid & ~busy_q;

  always_ff @(posedge clk_a) begin
    if (rst_a)        busy_q <= 1'b0;
    else if (take_a)  busy_q <= 1'b1;
    else if (rsp_hit) busy_q <= 1'b0;
  end

  xdom_tgl_tx #(.W(REQ_W)) u_a_tx (
    .clk   (clk_a),
    .rst   (rst_a),
    .load  (take_a),
    .din   (a_req_data),
    .tgl   (a2b_tgl),
    .dhold (a2b_word)
  );

  // ---------------- side B ----------------
  logic             pend_q;
  logic             take_b;
  logic             req_hit;
  logic             b2a_tgl;
  logic [RSP_W-1:0] b2a_word;

  assign b_rsp_ready = pend_q;
  assign take_b      = b_rsp_valid & pend_q;

  always_ff @(posedge clk_b) begin
    if (rst_b)        pend_q <= 1'b0;
    else if (req_hit) pend_q <= 1'b1;
    else if (take_b)  pend_q <= 1'b0;
  end

  xdom_tgl_rx #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_b_rx (
    .clk     (clk_b),
    .rst     (rst_b),
    .tgl_far (a2b_tgl),
    .din_far (a2b_word),
    .hit     (req_hit),
    .vld     (b_req_valid),
    .dout    (b_req_data)
  );

  xdom_tgl_tx #(.W(RSP_W)) u_b_tx (
    .clk   (clk_b),
    .rst   (rst_b),
    .load  (take_b),
    .din   (b_rsp_data),
    .tgl   (b2a_tgl),
    .dhold (b2a_word)
  );

  // ------------- back on side A -------------
  xdom_tgl_rx #(.W(RSP_W), .STAGES(SYNC_STAGES)) u_a_rx (
    .clk     (clk_a),
    .rst     (rst_a),
    .tgl_far (b2a_tgl),
    .din_far (b2a_word),
    .hit     (rsp_hit),
    .vld     (a_rsp_valid),
    .dout    (a_rsp_data)
  );
endmodule

// File: rtl/xdom_req_resp_chk.sv
module xdom_req_resp_chk #(
  parameter int unsigned REQ_W = 16,
  parameter int unsigned RSP_W = 12
) (
  input logic             clk_a,
  input logic             rst_a,
  input logic             a_req_valid,
  input logic             a_req_ready,
  input logic             a_rsp_valid,
  input logic [RSP_W-1:0] a_rsp_data,
  input logic             clk_b,
  input logic             rst_b,
  input logic             b_req_valid,
  input logic [REQ_W-1:0] b_req_data,
  input logic             b_rsp_valid,
  input logic             b_rsp_ready
);
  // R2
  a_busy_after_take_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_req_valid && a_req_ready) |=> !a_req_ready);

  // R4
  b_req_single_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    b_req_valid |=> !b_req_valid);

  // R4
  a_rsp_single_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    a_rsp_valid |=> !a_rsp_valid);

  // R5
  b_ready_with_req_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    b_req_valid |-> b_rsp_ready);

  // R5
  b_ready_drop_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    (b_rsp_valid && b_rsp_ready) |=> !b_rsp_ready);

  // R6
  a_ready_return_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    $rose(a_req_ready) |-> a_rsp_valid);

  // R8
  b_data_hold_chk: assert property (@(posedge clk_b) disable iff (rst_b)
    !b_req_valid |-> $stable(b_req_data));

  // R8
  a_data_hold_chk: assert property (@(posedge clk_a) disable iff (rst_a)
    !a_rsp_valid |-> $stable(a_rsp_data));
endmodule

bind xdom_req_resp xdom_req_resp_chk #(.REQ_W(REQ_W), .RSP_W(RSP_W)) u_chk (
  .clk_a       (clk_a),
  .rst_a       (rst_a),
  .a_req_valid (a_req_valid),
  .a_req_ready (a_req_ready),
  .a_rsp_valid (a_rsp_valid),
  .a_rsp_data  (a_rsp_data),
  .clk_b       (clk_b),
  .rst_b       (rst_b),
  .b_req_valid (b_req_valid),
  .b_req_data  (b_req_data),
  .b_rsp_valid (b_rsp_valid),
  .b_rsp_ready (b_rsp_ready)
);

// File: tb/tb_xdom_req_resp.sv
`timescale 1ns/1ps
module tb_xdom_req_resp;
  localparam int REQ_W  = 16;
  localparam int RSP_W  = 12;
  localparam int N_XFER = 40;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a = 1'b1, rst_b = 1'b1;
  logic             a_req_valid = 1'b0;
  logic             a_req_ready;
  logic [REQ_W-1:0] a_req_data  = '0;
  logic             a_rsp_valid;
  logic [RSP_W-1:0] a_rsp_data;
  logic             b_req_valid;
  logic [REQ_W-1:0] b_req_data;
  logic             b_rsp_valid = 1'b0;
  logic             b_rsp_ready;
  logic [RSP_W-1:0] b_rsp_data  = '0;

  xdom_req_resp #(.REQ_W(REQ_W), .RSP_W(RSP_W)) dut (
    .clk_a(clk_a), .rst_a(rst_a), .a_req_valid(a_req_valid), .a_req_ready(a_req_ready),
    .a_req_data(a_req_data), .a_rsp_valid(a_rsp_valid), .a_rsp_data(a_rsp_data),
    .clk_b(clk_b), .rst_b(rst_b), .b_req_valid(b_req_valid), .b_req_data(b_req_data),
    .b_rsp_valid(b_rsp_valid), .b_rsp_ready(b_rsp_ready), .b_rsp_data(b_rsp_data)
  );

  always #4 clk_a = ~clk_a;            // 125 MHz
  initial begin
    #1.3;
    forever #5.5 clk_b = ~clk_b;       // unrelated clock
  end

  int checks = 0, fails = 0;
  int rsp_seen = 0;
  bit reset_done = 1'b0, r5_done = 1'b0;
  logic [REQ_W-1:0] req_q[$];
  logic [RSP_W-1:0] rsp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [RSP_W-1:0] rsp_of(input logic [REQ_W-1:0] d);
    return RSP_W'(d ^ (d >> 5) ^ 16'h3A5C);
  endfunction

  function automatic logic [REQ_W-1:0] pattern(input int i);
    case (i % 5)
      0:       return 16'h0000;
      1:       return 16'hFFFF;
      2:       return 16'hAAAA ^ REQ_W'(i);
      3:       return 16'h5555 + REQ_W'(i);
      default: return REQ_W'(i * 16'h1F3D + 7);
    endcase
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_a);
    fails++;
    $display("FAIL watchdog: actual %0d responses expected %0d", rsp_seen, N_XFER);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  // side A monitor: pops expected responses
  initial begin
    bit prev_v = 1'b0;
    forever begin
      @(negedge clk_a);
      if (reset_done) begin
        if (a_rsp_valid) begin
          if (rsp_q.size() == 0) begin
            chk(1'b0, "R5", "response with none accepted", a_rsp_data, 0);
          end else begin
            logic [RSP_W-1:0] e;
            e = rsp_q.pop_front();
            chk(a_rsp_data == e, "R6", "response word", a_rsp_data, e);
            chk(a_req_ready, "R6", "ready with response", a_req_ready, 1);
          end
          rsp_seen++;
          if (prev_v) chk(1'b0, "R4", "response pulse longer than 1", 1, 0);
        end
        prev_v = a_rsp_valid;
      end
    end
  end

  // side B monitor and responder
  initial begin
    int n = 0;
    wait (reset_done);
    // R5: offers while nothing is pending must be ignored
    repeat (3) begin
      @(negedge clk_b);
      chk(b_rsp_ready == 1'b0, "R5", "ready while idle", b_rsp_ready, 0);
      b_rsp_valid = 1'b1;
      b_rsp_data  = 12'h777;
    end
    @(negedge clk_b);
    b_rsp_valid = 1'b0;
    r5_done = 1'b1;
    forever begin
      @(negedge clk_b);
      if (b_req_valid) begin
        logic [REQ_W-1:0] got;
        logic [RSP_W-1:0] r;
        got = b_req_data;
        if (req_q.size() == 0) begin
          chk(1'b0, "R3", "request with none accepted", got, 0);
          r = '0;
        end else begin
          logic [REQ_W-1:0] e;
          e = req_q.pop_front();
          chk(got == e, "R3", "request word", got, e);
          r = rsp_of(e);
        end
        chk(b_rsp_ready, "R5", "ready with request", b_rsp_ready, 1);
        @(negedge clk_b);
        chk(!b_req_valid, "R4", "request pulse width", b_req_valid, 0);
        chk(b_req_data == got, "R8", "request word held", b_req_data, got);
        repeat (n % 4) @(negedge clk_b);
        b_rsp_valid = 1'b1;
        b_rsp_data  = r;
        @(negedge clk_b);
        rsp_q.push_back(r);
        b_rsp_valid = 1'b0;
        b_rsp_data  = ~r;
        chk(!b_rsp_ready, "R5", "ready after response", b_rsp_ready, 0);
        n++;
      end
    end
  end

  task automatic send_req(input logic [REQ_W-1:0] d, input bit junk);
    @(negedge clk_a);
    while (!a_req_ready) @(negedge clk_a);
    a_req_valid = 1'b1;
    a_req_data  = d;
    @(negedge clk_a);
    req_q.push_back(d);
    chk(!a_req_ready, "R2", "ready after accept", a_req_ready, 0);
    if (junk) begin
      // R7: offer stays up while busy; must not reach side B
      a_req_data = d ^ 16'h1234;
      repeat (2) @(negedge clk_a);
      chk(!a_req_ready, "R2", "ready held low while busy", a_req_ready, 0);
    end
    a_req_valid = 1'b0;
  endtask

  initial begin
    repeat (6) @(negedge clk_a);
    // R1 reset values
    chk(a_req_ready == 1'b1, "R1", "a_req_ready in reset", a_req_ready, 1);
    chk(a_rsp_valid == 1'b0, "R1", "a_rsp_valid in reset", a_rsp_valid, 0);
    chk(b_req_valid == 1'b0, "R1", "b_req_valid in reset", b_req_valid, 0);
    chk(b_rsp_ready == 1'b0, "R1", "b_rsp_ready in reset", b_rsp_ready, 0);
    rst_a = 1'b0;
    @(negedge clk_b);
    rst_b = 1'b0;
    reset_done = 1'b1;
    wait (r5_done);
    repeat (10) @(negedge clk_a);
    chk(rsp_seen == 0, "R5", "ignored offers gave no response", rsp_seen, 0);
    chk(a_req_ready, "R5", "side A still idle", a_req_ready, 1);
    for (int i = 0; i < N_XFER; i++) send_req(pattern(i), (i % 3) == 0);
    while (rsp_seen < N_XFER) @(negedge clk_a);
    repeat (30) @(negedge clk_a);
    chk(req_q.size() == 0, "R7", "no stray requests pending", req_q.size(), 0);
    chk(rsp_q.size() == 0, "R6", "every response delivered", rsp_q.size(), 0);
    chk(rsp_seen == N_XFER, "R3", "one round trip per request", rsp_seen, N_XFER);
    chk(a_req_ready, "R6", "idle after last response", a_req_ready, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule